// File: doc/BRIEF.md
# Indirect Interrupt Routing Register File

This block holds the programming state of an I/O interrupt router. Software reaches it through just two 32-bit bus locations. A select register names one internal register, and a data window reads or writes whichever internal register is currently selected.

Inside there is an identification register, a read-only version register that reports how many table entries exist, an arbitration identifier register, and a table of 64-bit redirection entries, one per interrupt input. Each entry is split into two 32-bit halves that sit at consecutive select values.

The decoded fields of every entry are driven out continuously so that the dispatch logic can use them. Interrupt detection and message delivery belong to that neighbouring logic and are not part of this block.

The bus is a plain strobe interface. `busWr` or `busRd` is high for one cycle together with a byte offset. Read data, the bus error flag and the select error flag are all registered, so they appear in the cycle after the strobe. A write takes effect at the clock edge that samples it.

Top module: `irq_route_regs`

## Requirements
- R1: Bus offset 0 is the select register. A write stores bits 7:0 of the write data. A read returns the stored value in bits 7:0, with bits 31:8 zero. The select register resets to 0.
- R2: Bus offset 16 is the data window, which accesses the internal register named by the select value. Read data, `busErr` and `selErr` are registered and valid in the cycle after the strobe.
- R3: Select value 0 is the identification register. A write keeps data bits 31:24. A read returns the identifier in bits 31:24, with all other bits zero. `idOut` shows the stored value.
- R4: Select value 1 is read-only. It reads as (ENTRIES−1) in bits 23:16 and VERSION in bits 7:0, with every other bit zero. Writes to it change nothing. With the defaults it reads 0x00170011.
- R5: Select value 2 is the arbitration identifier. It behaves like R3 in bits 31:24 and is shown on `arbIdOut`.
- R6: Select values from 0x10 up to 0x10+2×ENTRIES−1 address the table. The entry number is (select−0x10)/2. An even select value accesses entry bits 31:0 and an odd select value accesses entry bits 63:32. A write touches no other entry and no other half.
- R7: The entry fields are as follows. Bits 7:0 hold the vector and bits 10:8 the delivery mode. Bit 11 is the destination mode, bit 13 the polarity, bit 15 the trigger mode and bit 16 the mask. Bits 63:56 hold the destination. All other bits are reserved, are forced to zero by a write to their half, and read back as zero. So a low half keeps the bits in 0x0001AFFF and a high half keeps the bits in 0xFF000000.
- R8: Reset state:
  - every entry has only its mask bit set, so its low half reads 0x00010000 and its high half reads 0;
  - the identifier and the arbitration identifier hold RESET_ID, which must be below 0xFF.
- R9: A data window access with an undefined select value does three things:
  - a read returns zero;
  - a write changes nothing;
  - `selErr` goes high for exactly one cycle.
  Undefined select values are 3 to 0x0F and values from 0x10+2×ENTRIES upward.
- R10: A bus access to any offset other than 0 or 16 raises `busErr` for one cycle, reads as zero and changes no state.
- R11: For entry n, the outputs `entVector`, `entDelivery`, `entDestMode`, `entPolarity`, `entTrigger`, `entMask` and `entDest` show that entry's stored fields, in the lanes for n. The outputs change in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRd | input | 1 | Read strobe, one cycle per access |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| busErr | output | 1 | Access to an undefined bus offset (one cycle) |
| selErr | output | 1 | Window access with an undefined select value (one cycle) |
| idOut | output | 8 | Identification register |
| arbIdOut | output | 8 | Arbitration identifier |
| entVector | output | ENTRIES*8 | Vector of each entry |
| entDelivery | output | ENTRIES*3 | Delivery mode of each entry |
| entDestMode | output | ENTRIES | Destination mode of each entry |
| entPolarity | output | ENTRIES | Polarity of each entry |
| entTrigger | output | ENTRIES | Trigger mode of each entry |
| entMask | output | ENTRIES | Mask bit of each entry |
| entDest | output | ENTRIES*8 | Destination of each entry |

## Verification
The assertions assume that `busRd` and `busWr` are never high in the same cycle, and one property checks that assumption. The no-change and version checks also rely on the select register being read in the same cycle as the strobe.

The bench keeps within these limits. Its tasks raise exactly one strobe for one cycle, always on a falling edge, and then leave an idle cycle before the next access. Every select write therefore settles before the window access that uses it.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int SEL_W     = 8;
  localparam int ENT_IDX_W = 7;
  localparam int TABLE_BASE = 16;

  // Bits each half keeps on a write; the rest are reserved.
  localparam logic [31:0] LO_KEEP = 32'h0001_AFFF;
  localparam logic [31:0] HI_KEEP = 32'hFF00_0000;
  localparam logic [31:0] LO_RESET = 32'h0001_0000;

  typedef enum logic [2:0] {
    SRC_ZERO,
    SRC_SEL,
    SRC_ID,
    SRC_VER,
    SRC_ARB,
    SRC_LO,
    SRC_HI
  } rdSrc_e;

  typedef struct packed {
    logic                 selWr;
    logic                 idWr;
    logic                 arbWr;
    logic                 loWr;
    logic                 hiWr;
    logic [ENT_IDX_W-1:0] entry;
    logic                 rdPulse;
    rdSrc_e               src;
    logic                 badSel;
    logic                 badBus;
  } strobe_t;

endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int ENTRIES = 24
) (
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [SEL_W-1:0]  selQ,
  output strobe_t           strb
);

  localparam int TABLE_END = TABLE_BASE + 2 * ENTRIES;

  logic isSelOff;
  logic isWin;
  logic anyAcc;
  logic inTable;
  logic [SEL_W-1:0] relIdx;
  rdSrc_e winSrc;
  logic winBad;

  assign isSelOff = (busAddr == ADDR_W'(0));
  assign isWin    = (busAddr == ADDR_W'(16));
  assign anyAcc   = busWr | busRd;
  assign inTable  = (int'(selQ) >= TABLE_BASE) && (int'(selQ) < TABLE_END);
  assign relIdx   = selQ - SEL_W'(TABLE_BASE);

  always_comb begin
    winBad = 1'b0;
    winSrc = SRC_ZERO;
    case (selQ)
      8'h00:   winSrc = SRC_ID;
      8'h01:   winSrc = SRC_VER;
      8'h02:   winSrc = SRC_ARB;
      default: begin
        if (inTable) begin
          winSrc = selQ[0] ? SRC_HI : SRC_LO;
        end else begin
          winBad = 1'b1;
        end
      end
    endcase
  end

  always_comb begin
    strb         = '0;
    strb.entry   = relIdx[ENT_IDX_W:1];
    strb.rdPulse = busRd;
    strb.src     = SRC_ZERO;
    if (isSelOff) begin
      strb.selWr = busWr;
      strb.src   = SRC_SEL;
    end else if (isWin) begin
      strb.src    = winSrc;
      strb.badSel = anyAcc & winBad;
      strb.idWr   = busWr & (winSrc == SRC_ID);
      strb.arbWr  = busWr & (winSrc == SRC_ARB);
      strb.loWr   = busWr & (winSrc == SRC_LO);
      strb.hiWr   = busWr & (winSrc == SRC_HI);
    end else begin
      strb.badBus = anyAcc;
    end
  end

  // R6
  tableStrobe_chk: assert final (!(strb.loWr || strb.hiWr) || (int'(strb.entry) < ENTRIES));

endmodule

// File: rtl/irq_route_entry.sv
module irq_route_entry
  import irq_route_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        loWr,
  input  logic        hiWr,
  input  logic [31:0] wdata,
  output logic [31:0] loQ,
  output logic [31:0] hiQ
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loQ <= LO_RESET;
      hiQ <= '0;
    end else begin
      if (loWr) loQ <= wdata & LO_KEEP;
      if (hiWr) hiQ <= wdata & HI_KEEP;
    end
  end

endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
#(
  parameter int          ENTRIES  = 24,
  parameter logic [7:0]  RESET_ID = 8'h02,
  parameter logic [7:0]  VERSION  = 8'h11
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  logic [31:0]           busWdata,
  output logic [31:0]           busRdata,
  output logic                  busErr,
  output logic                  selErr,
  output logic [SEL_W-1:0]      selQ,
  output logic [7:0]            idQ,
  output logic [7:0]            arbQ,
  output logic [ENTRIES*32-1:0] loFlat,
  output logic [ENTRIES*32-1:0] hiFlat
);

  localparam logic [7:0]  LAST_IDX = 8'(ENTRIES - 1);
  localparam logic [31:0] VER_WORD = {8'h00, LAST_IDX, 8'h00, VERSION};

  logic [31:0] loArr [ENTRIES];
  logic [31:0] hiArr [ENTRIES];
  logic [31:0] pickLo;
  logic [31:0] pickHi;
  logic [31:0] rdMux;

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    irq_route_entry u_entry (
      .clk   (clk),
      .rstN  (rstN),
      .loWr  (strb.loWr && (strb.entry == ENT_IDX_W'(g))),
      .hiWr  (strb.hiWr && (strb.entry == ENT_IDX_W'(g))),
      .wdata (busWdata),
      .loQ   (loArr[g]),
      .hiQ   (hiArr[g])
    );
    assign loFlat[g*32 +: 32] = loArr[g];
    assign hiFlat[g*32 +: 32] = hiArr[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ <= '0;
      idQ  <= RESET_ID;
      arbQ <= RESET_ID;
    end else begin
      if (strb.selWr) selQ <= busWdata[SEL_W-1:0];
      if (strb.idWr)  idQ  <= busWdata[31:24];
      if (strb.arbWr) arbQ <= busWdata[31:24];
    end
  end

  always_comb begin
    pickLo = '0;
    pickHi = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (strb.entry == ENT_IDX_W'(k)) begin
        pickLo = loArr[k];
        pickHi = hiArr[k];
      end
    end
  end

  always_comb begin
    case (strb.src)
      SRC_SEL: rdMux = {{(32-SEL_W){1'b0}}, selQ};
      SRC_ID:  rdMux = {idQ, 24'h0};
      SRC_VER: rdMux = VER_WORD;
      SRC_ARB: rdMux = {arbQ, 24'h0};
      SRC_LO:  rdMux = pickLo;
      SRC_HI:  rdMux = pickHi;
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
      busErr   <= 1'b0;
      selErr   <= 1'b0;
    end else begin
      if (strb.rdPulse) busRdata <= rdMux;
      busErr <= strb.badBus;
      selErr <= strb.badSel;
    end
  end

  // R8
  resetIdRange_chk: assert final (RESET_ID != 8'hFF);

  // R9
  selErrPulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    selErr |=> (!selErr || $past(strb.badSel)));

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int         ADDR_W   = 5,
  parameter int         ENTRIES  = 24,
  parameter logic [7:0] RESET_ID = 8'h02,
  parameter logic [7:0] VERSION  = 8'h11
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWr,
  input  logic                 busRd,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output logic                 busErr,
  output logic                 selErr,
  output logic [7:0]           idOut,
  output logic [7:0]           arbIdOut,
  output logic [ENTRIES*8-1:0] entVector,
  output logic [ENTRIES*3-1:0] entDelivery,
  output logic [ENTRIES-1:0]   entDestMode,
  output logic [ENTRIES-1:0]   entPolarity,
  output logic [ENTRIES-1:0]   entTrigger,
  output logic [ENTRIES-1:0]   entMask,
  output logic [ENTRIES*8-1:0] entDest
);

  localparam logic [31:0] VER_WORD = {8'h00, 8'(ENTRIES - 1), 8'h00, VERSION};

  strobe_t strb;
  logic [SEL_W-1:0] selQ;
  logic [ENTRIES*32-1:0] loFlat;
  logic [ENTRIES*32-1:0] hiFlat;

  irq_route_ctrl #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_ctrl (
    .busWr   (busWr),
    .busRd   (busRd),
    .busAddr (busAddr),
    .selQ    (selQ),
    .strb    (strb)
  );

  irq_route_dp #(.ENTRIES(ENTRIES), .RESET_ID(RESET_ID), .VERSION(VERSION)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .busErr   (busErr),
    .selErr   (selErr),
    .selQ     (selQ),
    .idQ      (idOut),
    .arbQ     (arbIdOut),
    .loFlat   (loFlat),
    .hiFlat   (hiFlat)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : gField
    assign entVector[g*8 +: 8]   = loFlat[g*32 +: 8];
    assign entDelivery[g*3 +: 3] = loFlat[g*32 + 8 +: 3];
    assign entDestMode[g]        = loFlat[g*32 + 11];
    assign entPolarity[g]        = loFlat[g*32 + 13];
    assign entTrigger[g]         = loFlat[g*32 + 15];
    assign entMask[g]            = loFlat[g*32 + 16];
    assign entDest[g*8 +: 8]     = hiFlat[g*32 + 24 +: 8];
  end

  // R2
  oneStrobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr));

  // R1
  selWrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(0)) |=> (selQ == $past(busWdata[7:0])));

  // R3
  idWrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(16) && selQ == 8'h00) |=> (idOut == $past(busWdata[31:24])));

  // R4
  verRead_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == ADDR_W'(16) && selQ == 8'h01) |=> (busRdata == VER_WORD));

  // R9
  selErrCause_chk: assert property (@(posedge clk) disable iff (!rstN)
    selErr |-> ($past(busRd || busWr) && $past(busAddr) == ADDR_W'(16)));

  // R10
  badOffset_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((busRd || busWr) && busAddr != ADDR_W'(0) && busAddr != ADDR_W'(16))
      |=> (busErr && !selErr && $stable(selQ) && $stable(idOut) && $stable(arbIdOut)
           && $stable(loFlat) && $stable(hiFlat)));

endmodule

// File: tb/irq_route_regs_bench.sv
module irq_route_regs_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0;
  logic busRd = 1'b0;
  logic [4:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic busErr, selErr;
  logic [7:0] idOut, arbIdOut;
  logic [N*8-1:0] entVector, entDest;
  logic [N*3-1:0] entDelivery;
  logic [N-1:0] entDestMode, entPolarity, entTrigger, entMask;

  int checks = 0;
  int fails = 0;
  logic lastErr, lastSelErr;

  irq_route_regs u_irq_route_regs (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busErr(busErr), .selErr(selErr),
    .idOut(idOut), .arbIdOut(arbIdOut), .entVector(entVector),
    .entDelivery(entDelivery), .entDestMode(entDestMode),
    .entPolarity(entPolarity), .entTrigger(entTrigger), .entMask(entMask),
    .entDest(entDest)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
    lastErr = busErr; lastSelErr = selErr;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busRd = 1'b1; busAddr = a;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
    lastErr = busErr; lastSelErr = selErr;
  endtask

  task automatic winRead(input logic [7:0] sel, output logic [31:0] d);
    busWrite(5'd0, {24'h0, sel});
    busRead(5'd16, d);
  endtask

  task automatic winWrite(input logic [7:0] sel, input logic [31:0] d);
    busWrite(5'd0, {24'h0, sel});
    busWrite(5'd16, d);
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R8 id reset", idOut, 8'h02);
    check("R8 arb reset", arbIdOut, 8'h02);
    check("R8 masks set", entMask, {N{1'b1}});
    check("R8 vectors zero", entVector, '0);
    busRead(5'd0, d);
    check("R1 select reset", d, 0);
    winRead(8'h10, d);
    check("R8 entry0 low", d, 32'h0001_0000);
    winRead(8'h11, d);
    check("R8 entry0 high", d, 0);
  endtask

  task automatic testSelect();
    logic [31:0] d;
    busWrite(5'd0, 32'h0000_0013);
    busRead(5'd0, d);
    check("R1 select rw", d, 32'h13);
    busWrite(5'd0, 32'hABCD_1234);
    busRead(5'd0, d);
    check("R1 select low byte", d, 32'h34);
    check("R2 no bus err", lastErr, 1'b0);
  endtask

  task automatic testIdRegs();
    logic [31:0] d;
    winWrite(8'h00, 32'hA5FF_FFFF);
    check("R3 idOut", idOut, 8'hA5);
    busRead(5'd16, d);
    check("R3 id read", d, 32'hA500_0000);
    winWrite(8'h02, 32'h3C12_3456);
    check("R5 arbIdOut", arbIdOut, 8'h3C);
    busRead(5'd16, d);
    check("R5 arb read", d, 32'h3C00_0000);
    check("R3 id kept", idOut, 8'hA5);
  endtask

  task automatic testVersion();
    logic [31:0] d;
    winRead(8'h01, d);
    check("R4 version", d, 32'h0017_0011);
    busWrite(5'd16, 32'hFFFF_FFFF);
    busRead(5'd16, d);
    check("R4 version read-only", d, 32'h0017_0011);
    check("R4 no sel err", lastSelErr, 1'b0);
  endtask

  task automatic testEntry();
    logic [31:0] d;
    winWrite(8'h16, 32'hFFFF_FFFF);
    busRead(5'd16, d);
    check("R7 low reserved cleared", d, 32'h0001_AFFF);
    check("R11 vector3", entVector[3*8 +: 8], 8'hFF);
    check("R11 delivery3", entDelivery[3*3 +: 3], 3'h7);
    check("R11 flags3", {entDestMode[3], entPolarity[3], entTrigger[3], entMask[3]}, 4'hF);
    winWrite(8'h17, 32'hFFFF_FFFF);
    busRead(5'd16, d);
    check("R7 high reserved cleared", d, 32'hFF00_0000);
    check("R11 dest3", entDest[3*8 +: 8], 8'hFF);
    check("R6 neighbour2 untouched", {entVector[2*8 +: 8], entDest[2*8 +: 8]}, 16'h0);
    check("R6 neighbour4 untouched", {entVector[4*8 +: 8], entDest[4*8 +: 8]}, 16'h0);
    winWrite(8'h16, 32'h0000_0842);
    check("R6 low write keeps high", entDest[3*8 +: 8], 8'hFF);
    check("R11 vector3 rewritten", entVector[3*8 +: 8], 8'h42);
    check("R11 mask3 cleared", entMask[3], 1'b0);
    check("R11 destmode3", entDestMode[3], 1'b1);
  endtask

  task automatic testLastEntry();
    logic [31:0] d;
    winWrite(8'h3E, 32'h0000_0031);
    check("R6 last vector", entVector[23*8 +: 8], 8'h31);
    check("R6 last mask", entMask[23], 1'b0);
    winWrite(8'h3F, 32'h5A00_0000);
    check("R6 last dest", entDest[23*8 +: 8], 8'h5A);
    busRead(5'd16, d);
    check("R6 last high read", d, 32'h5A00_0000);
    check("R9 no sel err in table", lastSelErr, 1'b0);
  endtask

  task automatic testBadSelect();
    logic [31:0] d;
    logic [N*8-1:0] vecBefore;
    logic [N-1:0] maskBefore;
    vecBefore = entVector; maskBefore = entMask;
    winRead(8'h40, d);
    check("R9 past table reads zero", d, 0);
    check("R9 past table sel err", lastSelErr, 1'b1);
    busWrite(5'd16, 32'hFFFF_FFFF);
    check("R9 write sel err", lastSelErr, 1'b1);
    @(negedge clk);
    check("R9 sel err one cycle", selErr, 1'b0);
    check("R9 entries untouched", {vecBefore, maskBefore} == {entVector, entMask}, 1'b1);
    winRead(8'h03, d);
    check("R9 sel 3 zero", d, 0);
    check("R9 sel 3 err", lastSelErr, 1'b1);
    winWrite(8'h0F, 32'hFFFF_FFFF);
    check("R9 sel F err", lastSelErr, 1'b1);
    check("R9 ids untouched", {idOut, arbIdOut}, 16'hA53C);
  endtask

  task automatic testBadOffset();
    logic [31:0] d;
    busWrite(5'd0, 32'h10);
    busRead(5'd4, d);
    check("R10 read err", lastErr, 1'b1);
    check("R10 read zero", d, 0);
    busWrite(5'd8, 32'h0000_0002);
    check("R10 write err", lastErr, 1'b1);
    busWrite(5'd20, 32'hFFFF_FFFF);
    check("R10 err at 20", lastErr, 1'b1);
    @(negedge clk);
    check("R10 err one cycle", busErr, 1'b0);
    busRead(5'd0, d);
    check("R10 select unchanged", d, 32'h10);
    check("R10 no err on good", lastErr, 1'b0);
    busRead(5'd16, d);
    check("R10 entry0 unchanged", d, 32'h0001_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSelect();
    testIdRegs();
    testVersion();
    testEntry();
    testLastEntry();
    testBadSelect();
    testBadOffset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule